// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block contains two timer/counter channels and one shared configuration byte. Each channel has a low byte and a high byte. A channel counts either machine cycles or falling edges on its own count pin. One machine cycle is a fixed number of system clocks. Each channel has four layouts:

- a 13-bit counter, with a 5-bit prescaler under an 8-bit upper byte;
- a 16-bit counter;
- an 8-bit counter with auto-reload;
- a split layout.

In the split layout, the high byte of channel 0 becomes a separate 8-bit timer. That timer is driven by the run bit of channel 1 and sets the flag of channel 1.

Software reaches the block through a small register port. Writes are synchronous and reads are combinational. Each channel has a gate pin. When gating is selected, a channel counts only while its gate pin is high, so the block can measure the width of a pulse. Every overflow of channel 1 produces a one-cycle pulse for an external baud-rate divider.

Top module: `dual_timer_counter`

## Requirements
- R1: After reset, every register reads 0, both flags are 0 and `baud_tick_o` is 0.
- R2: The register addresses are:
  - 0: configuration. Channel 1 uses bits 7:4 and channel 0 uses bits 3:0. In each nibble, bit 3 enables gating, bit 2 selects pin-edge counting (1) or machine-cycle counting (0), and bits 1:0 select the layout.
  - 1: control. Bit 0 is run 0, bit 1 is run 1, bit 2 is flag 0 and bit 3 is flag 1.
  - 2 and 3: low and high byte of channel 0.
  - 4 and 5: low and high byte of channel 1.
  - Reads are combinational. Addresses 6 and 7 read as 0.
- R3: Layout 0 counts the low 5 bits of the low byte as a prescaler below the high byte. The overflow is at {high, low[4:0]} = all ones. Low bits 7:5 keep their value.
- R4: Layout 1 counts {high, low} as one 16-bit value. The overflow is the roll from 0xFFFF to 0x0000.
- R5: Layout 2 counts the low byte only. On a roll from 0xFF, the low byte is loaded from the high byte, which is left unchanged.
- R6: In layout 3, the following apply:
  - Channel 0's low byte is an 8-bit counter that uses channel 0's controls and flag.
  - Channel 0's high byte counts machine cycles while run 1 is set, and its roll from 0xFF sets flag 1.
  - Channel 1 set to layout 3 holds its bytes.
- R7: While channel 0 is in layout 3, overflows of channel 1 never set flag 1. `baud_tick_o` pulses for one clock on every overflow of channel 1, in every layout.
- R8: With gating clear, a channel counts while its run bit is 1. With gating set, it also needs its gate pin to be high.
- R9: When counting machine cycles, a channel advances once every 12 clocks. The advance falls on the 12th, 24th, ... rising edge after reset is released.
- R10: When counting pin edges, the following apply:
  - The pin passes through two clock flops.
  - The pin is sampled on each machine-cycle boundary.
  - A sample of 1 followed by a sample of 0 counts one edge.
  - The edge is counted on the next machine-cycle boundary.
- R11: A register write to a low or high byte in the same clock as an increment stores the written value in that byte.
- R12: A flag is set by an overflow of its channel. Writing 0 to the flag's control bit clears it and writing 1 leaves it unchanged. When a set and a clear fall in the same clock, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for write and read |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data at `reg_addr_i` |
| gate_i | input | 2 | Gate pins, bit n for channel n |
| cnt_pin_i | input | 2 | Count pins, bit n for channel n |
| ovf_flag_o | output | 2 | Overflow flags, bit n for flag n |
| baud_tick_o | output | 1 | One-clock pulse on each channel 1 overflow |

## Verification
The bench targets the 13-bit prescaler wrap. A design that carried at 8 bits, or cleared low bits 7:5, would show wrong high-byte values. It also targets the auto-reload: a design that loaded zero, or changed the high byte, would drift from the expected period.

In the split layout, the bench checks that channel 1 drops its own flag while still pulsing the baud output. It also checks that channel 0's high byte runs on run 1 alone. A design that routed these wrongly would show a flag 1 that fires too often or never.

The bench toggles count pins at the fastest legal rate and writes bytes on the exact increment clock. A missing synchronizer stage would shift counts by one machine cycle, and a lost write priority would leave an incremented value instead of the written one.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int BYTE_W = 8;
  localparam int PRE_W  = 5;
  localparam int ADDR_W = 3;
  localparam int MC_DIV = 12;

  localparam logic [ADDR_W-1:0] ADDR_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_LO0  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_HI0  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_LO1  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_HI1  = 3'd5;

  typedef enum logic [1:0] {
    MODE_13B    = 2'd0,
    MODE_16B    = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } tc_mode_e;

  typedef struct packed {
    logic     gate;
    logic     ext;
    tc_mode_e mode;
  } tc_cfg_t;
endpackage

// File: rtl/tc_tick_gen.sv
module tc_tick_gen #(
  parameter int DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (cnt_q == CNT_LAST) cnt_q <= '0;
    else                       cnt_q <= cnt_q + CNT_ONE;
  end

  assign tick_o = (cnt_q == CNT_LAST);

  // R9
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tc_pin_edge.sv
module tc_pin_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pin_i,
  output logic fall_o
);
  logic sync1_q, sync2_q, smp_q, fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      smp_q   <= 1'b1;
      fall_q  <= 1'b0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      if (tick_i) begin
        smp_q  <= sync2_q;
        fall_q <= smp_q & ~sync2_q;
      end
    end
  end

  assign fall_o = fall_q;

  // R10 edge flag only changes on machine-cycle boundary
  edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(fall_o));
endmodule

// File: rtl/tc_channel.sv
module tc_channel
  import tc_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int PW = PRE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  tc_mode_e      mode_i,
  input  logic          inc_i,
  input  logic          aux_inc_i,
  input  logic          lo_we_i,
  input  logic          hi_we_i,
  input  logic [BW-1:0] wdata_i,
  output logic [BW-1:0] lo_o,
  output logic [BW-1:0] hi_o,
  output logic          ovf_o,
  output logic          aux_ovf_o
);
  localparam logic [PW-1:0]   PRE_ONE  = PW'(1);
  localparam logic [BW-1:0]   BYTE_ONE = BW'(1);
  localparam logic [2*BW-1:0] WORD_ONE = (2*BW)'(1);

  logic [BW-1:0] lo_q, hi_q, lo_n, hi_n;
  logic          ovf, aux_ovf;

  always_comb begin
    lo_n    = lo_q;
    hi_n    = hi_q;
    ovf     = 1'b0;
    aux_ovf = 1'b0;
    unique case (mode_i)
      MODE_13B: if (inc_i) begin
        if (&lo_q[PW-1:0]) begin
          lo_n[PW-1:0] = '0;
          hi_n         = hi_q + BYTE_ONE;
          ovf          = &hi_q;
        end else begin
          lo_n[PW-1:0] = lo_q[PW-1:0] + PRE_ONE;
        end
      end
      MODE_16B: if (inc_i) begin
        {hi_n, lo_n} = {hi_q, lo_q} + WORD_ONE;
        ovf          = &{hi_q, lo_q};
      end
      MODE_RELOAD: if (inc_i) begin
        if (&lo_q) begin
          lo_n = hi_q;
          ovf  = 1'b1;
        end else begin
          lo_n = lo_q + BYTE_ONE;
        end
      end
      MODE_SPLIT: begin
        if (inc_i) begin
          lo_n = lo_q + BYTE_ONE;
          ovf  = &lo_q;
        end
        if (aux_inc_i) begin
          hi_n    = hi_q + BYTE_ONE;
          aux_ovf = &hi_q;
        end
      end
      default: ;
    endcase
    // register write wins over the increment
    if (lo_we_i) lo_n = wdata_i;
    if (hi_we_i) hi_n = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assign lo_o      = lo_q;
  assign hi_o      = hi_q;
  assign ovf_o     = ovf;
  assign aux_ovf_o = aux_ovf;

  // R11
  lo_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_we_i |=> lo_o == $past(wdata_i));
  // R4
  wide_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_16B && inc_i && !lo_we_i && !hi_we_i)
      |=> {hi_o, lo_o} == $past({hi_o, lo_o}) + WORD_ONE);
  // R5
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_RELOAD && inc_i && &lo_o && !lo_we_i)
      |=> lo_o == $past(hi_o));
  // R3
  pre_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_13B && !lo_we_i) |=> lo_o[BW-1:PW] == $past(lo_o[BW-1:PW]));
endmodule

// File: rtl/dual_timer_counter.sv
module dual_timer_counter
  import tc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  input  logic [1:0]        gate_i,
  input  logic [1:0]        cnt_pin_i,
  output logic [1:0]        ovf_flag_o,
  output logic              baud_tick_o
);
  localparam int NCH = 2;

  tc_cfg_t [NCH-1:0] cfg_q;
  logic [NCH-1:0]    run_q, flag_q, flag_set, flag_keep;
  logic [NCH-1:0]    fall, en, inc, aux_inc, ovf, aux_ovf, lo_we, hi_we;
  logic [BYTE_W-1:0] lo [NCH];
  logic [BYTE_W-1:0] hi [NCH];
  logic              tick, split, ctrl_wr;

  tc_tick_gen #(.DIV(MC_DIV)) i_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  assign split   = (cfg_q[0].mode == MODE_SPLIT);
  assign ctrl_wr = reg_we_i && (reg_addr_i == ADDR_CTRL);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_LO = ADDR_LO0 + ADDR_W'(2 * c);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_HI0 + ADDR_W'(2 * c);
    logic src;

    tc_pin_edge i_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(tick),
      .pin_i (cnt_pin_i[c]),
      .fall_o(fall[c])
    );

    assign en[c]    = run_q[c] & (~cfg_q[c].gate | gate_i[c]);
    assign src      = cfg_q[c].ext ? fall[c] : 1'b1;
    assign lo_we[c] = reg_we_i && (reg_addr_i == A_LO);
    assign hi_we[c] = reg_we_i && (reg_addr_i == A_HI);

    if (c == 0) begin : g_main
      assign inc[c]     = tick & en[c] & src;
      assign aux_inc[c] = tick & run_q[1] & split;
    end else begin : g_other
      // layout 3 on this channel stops it
      assign inc[c]     = tick & en[c] & src & (cfg_q[c].mode != MODE_SPLIT);
      assign aux_inc[c] = 1'b0;
    end

    tc_channel i_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mode_i   (cfg_q[c].mode),
      .inc_i    (inc[c]),
      .aux_inc_i(aux_inc[c]),
      .lo_we_i  (lo_we[c]),
      .hi_we_i  (hi_we[c]),
      .wdata_i  (reg_wdata_i),
      .lo_o     (lo[c]),
      .hi_o     (hi[c]),
      .ovf_o    (ovf[c]),
      .aux_ovf_o(aux_ovf[c])
    );
  end

  assign flag_set[0] = ovf[0];
  assign flag_set[1] = split ? aux_ovf[0] : (ovf[1] | aux_ovf[1]);
  assign flag_keep   = ctrl_wr ? reg_wdata_i[3:2] : 2'b11;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      if (reg_we_i && reg_addr_i == ADDR_CFG) cfg_q <= reg_wdata_i;
      if (ctrl_wr) run_q <= reg_wdata_i[1:0];
      flag_q <= (flag_q & flag_keep) | flag_set;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CFG:  reg_rdata_o = cfg_q;
      ADDR_CTRL: reg_rdata_o = {4'b0, flag_q, run_q};
      ADDR_LO0:  reg_rdata_o = lo[0];
      ADDR_HI0:  reg_rdata_o = hi[0];
      ADDR_LO1:  reg_rdata_o = lo[1];
      ADDR_HI1:  reg_rdata_o = hi[1];
      default:   reg_rdata_o = '0;
    endcase
  end

  assign ovf_flag_o  = flag_q;
  assign baud_tick_o = ovf[1];

  // R12
  flag0_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf[0] |=> ovf_flag_o[0]);
  // R6
  ch1_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q[1].mode == MODE_SPLIT && !lo_we[1] && !hi_we[1])
      |=> ($stable(lo[1]) && $stable(hi[1])));
  // R7
  no_own_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (split && baud_tick_o && !aux_ovf[0] && !ovf_flag_o[1]) |=> !ovf_flag_o[1]);
  // R8
  gate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q[0].gate && !gate_i[0] && !split && !lo_we[0] && !hi_we[0])
      |=> ($stable(lo[0]) && $stable(hi[0])));
endmodule

// File: tb/test_dual_timer_counter.sv
module test_dual_timer_counter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] gate = '0;
  logic [1:0] pin = 2'b11;
  logic [1:0] flags;
  logic       baud;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  string cur_tag = "";

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_timer_counter i_dual_timer_counter (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .gate_i(gate),
    .cnt_pin_i(pin), .ovf_flag_o(flags), .baud_tick_o(baud)
  );

  // reference state
  int         m_pre;
  logic [1:0] m_s1, m_s2, m_smp, m_fall, m_run, m_flag;
  logic [7:0] m_cfg;
  logic [7:0] m_lo [2];
  logic [7:0] m_hi [2];

  function automatic void model_reset();
    m_pre = 0; m_s1 = 2'b11; m_s2 = 2'b11; m_smp = 2'b11; m_fall = 0;
    m_run = 0; m_flag = 0; m_cfg = 0;
    for (int c = 0; c < 2; c++) begin m_lo[c] = 0; m_hi[c] = 0; end
  endfunction

  function automatic void ch_step(input logic [1:0] md, input logic [7:0] lo, hi,
                                  input logic inc, aux,
                                  output logic [7:0] lo_n, hi_n, output logic ov, aov);
    logic [12:0] v13;
    logic [15:0] v16;
    lo_n = lo; hi_n = hi; ov = 0; aov = 0;
    if (md == 2'd0 && inc) begin
      v13 = {hi, lo[4:0]};
      ov = (v13 == 13'h1fff);
      v13 = v13 + 13'd1;
      hi_n = v13[12:5]; lo_n = {lo[7:5], v13[4:0]};
    end else if (md == 2'd1 && inc) begin
      v16 = {hi, lo};
      ov = (v16 == 16'hffff);
      v16 = v16 + 16'd1;
      {hi_n, lo_n} = v16;
    end else if (md == 2'd2 && inc) begin
      if (lo == 8'hff) begin lo_n = hi; ov = 1; end
      else lo_n = lo + 8'd1;
    end else if (md == 2'd3) begin
      if (inc) begin ov = (lo == 8'hff); lo_n = lo + 8'd1; end
      if (aux) begin aov = (hi == 8'hff); hi_n = hi + 8'd1; end
    end
  endfunction

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_cfg;
      3'd1: return {4'b0, m_flag, m_run};
      3'd2: return m_lo[0];
      3'd3: return m_hi[0];
      3'd4: return m_lo[1];
      3'd5: return m_hi[1];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_for(input logic [2:0] a);
    logic [1:0] md;
    if (cur_tag != "") return cur_tag;
    if (a == 3'd1) return "R12";
    if (a == 3'd0 || a > 3'd5) return "R2";
    md = (a < 3'd4) ? m_cfg[1:0] : m_cfg[5:4];
    if (md == 2'd3 || (a >= 3'd4 && m_cfg[1:0] == 2'd3)) return "R6";
    case (md)
      2'd0: return "R3";
      2'd1: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act %0h exp %0h", tag, what, act, exp);
    end
  endtask

  task automatic cycle(input logic w, input logic [2:0] a, input logic [7:0] d);
    logic       tick, sp;
    logic [1:0] md0, md1, inc, en, src, keep, set;
    logic [7:0] lo_n [2];
    logic [7:0] hi_n [2];
    logic       ov0, ov1, aov0, aov1;
    we = w; addr = a; wdata = d;
    #1;
    tick = (m_pre == 11);
    md0 = m_cfg[1:0]; md1 = m_cfg[5:4]; sp = (md0 == 2'd3);
    for (int c = 0; c < 2; c++) begin
      en[c]  = m_run[c] & (~m_cfg[4*c+3] | gate[c]);
      src[c] = m_cfg[4*c+2] ? m_fall[c] : 1'b1;
    end
    inc[0] = tick & en[0] & src[0];
    inc[1] = tick & en[1] & src[1] & (md1 != 2'd3);
    ch_step(md0, m_lo[0], m_hi[0], inc[0], tick & m_run[1] & sp, lo_n[0], hi_n[0], ov0, aov0);
    ch_step(md1, m_lo[1], m_hi[1], inc[1], 1'b0, lo_n[1], hi_n[1], ov1, aov1);
    check(baud === ov1, (cur_tag != "") ? cur_tag : "R7", "baud", baud, ov1);
    if (w && a == 3'd2) lo_n[0] = d;
    if (w && a == 3'd3) hi_n[0] = d;
    if (w && a == 3'd4) lo_n[1] = d;
    if (w && a == 3'd5) hi_n[1] = d;
    keep = (w && a == 3'd1) ? d[3:2] : 2'b11;
    set  = {sp ? aov0 : ov1, ov0};
    @(posedge clk);
    m_flag = (m_flag & keep) | set;
    if (w && a == 3'd1) m_run = d[1:0];
    if (w && a == 3'd0) m_cfg = d;
    if (tick) begin m_fall = m_smp & ~m_s2; m_smp = m_s2; end
    m_s2 = m_s1; m_s1 = pin;
    m_pre = tick ? 0 : m_pre + 1;
    for (int c = 0; c < 2; c++) begin m_lo[c] = lo_n[c]; m_hi[c] = hi_n[c]; end
    @(negedge clk);
    check(rdata === exp_rd(a), tag_for(a), $sformatf("rdata@%0d", a), rdata, exp_rd(a));
    check(flags === m_flag, (cur_tag != "") ? cur_tag : "R12", "flags", flags, m_flag);
  endtask

  int rd_ptr = 0;
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      cycle(1'b0, 3'(rd_ptr), 8'h00);
      rd_ptr = (rd_ptr + 1) % 6;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cycle(1'b1, a, d);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cur_tag = "R1";
    for (int a = 0; a < 8; a++) cycle(1'b0, 3'(a), 8'h00);

    // R2 register map readback
    cur_tag = "R2";
    wr(3'd0, 8'h00); wr(3'd2, 8'hA5); wr(3'd3, 8'h5A); wr(3'd4, 8'h3C); wr(3'd5, 8'hC3);
    idle(8);

    // R9 machine-cycle timer rate, 16-bit layout on channel 0
    cur_tag = "R9";
    wr(3'd0, 8'h01); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h01);
    idle(60);

    // R3 13-bit prescaler wrap with upper low bits preset
    cur_tag = "R3";
    wr(3'd1, 8'h00); wr(3'd0, 8'h00); wr(3'd2, 8'hFC); wr(3'd3, 8'hFF); wr(3'd1, 8'h01);
    idle(120);

    // R4 16-bit roll
    cur_tag = "R4";
    wr(3'd1, 8'h00); wr(3'd0, 8'h01); wr(3'd2, 8'hFD); wr(3'd3, 8'hFF); wr(3'd1, 8'h01);
    idle(60);

    // R5 reload on channel 1
    cur_tag = "R5";
    wr(3'd1, 8'h00); wr(3'd0, 8'h20); wr(3'd5, 8'hFB); wr(3'd4, 8'hFD); wr(3'd1, 8'h02);
    idle(150);

    // R12 clear by zero, write one keeps
    cur_tag = "R12";
    wr(3'd1, 8'h0E); idle(2); wr(3'd1, 8'h02); idle(4);

    // R8 gating
    cur_tag = "R8";
    wr(3'd1, 8'h00); wr(3'd0, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h01);
    gate = 2'b00; idle(50); gate = 2'b01; idle(50); gate = 2'b00; idle(30);

    // R10 counter mode at fastest pin rate and slow rate
    cur_tag = "R10";
    wr(3'd1, 8'h00); wr(3'd0, 8'h45); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h03);
    for (int i = 0; i < 400; i++) begin
      if (i % 12 == 0) pin[0] = ~pin[0];
      if (i % 30 == 0) pin[1] = ~pin[1];
      idle(1);
    end

    // R6 split layout, channel 1 stopped in layout 3
    cur_tag = "R6";
    wr(3'd1, 8'h00); wr(3'd0, 8'h33); wr(3'd3, 8'hFD); wr(3'd2, 8'hFE);
    wr(3'd4, 8'h11); wr(3'd5, 8'h22); wr(3'd1, 8'h03);
    idle(80);

    // R7 channel 1 near overflow while split: baud only, no flag 1 from it
    cur_tag = "R7";
    wr(3'd1, 8'h00); wr(3'd0, 8'h13); wr(3'd3, 8'h00); wr(3'd4, 8'hFE); wr(3'd5, 8'hFF);
    wr(3'd1, 8'h02);
    idle(60);

    // R11 write on the exact increment clock
    cur_tag = "R11";
    wr(3'd1, 8'h00); wr(3'd0, 8'h01); wr(3'd2, 8'h10); wr(3'd1, 8'h01);
    for (int k = 0; k < 4; k++) begin
      while (m_pre != 11) idle(1);
      wr(3'd2, 8'h77 + 8'(k));
      while (m_pre != 11) idle(1);
      wr(3'd3, 8'hFF);
    end
    idle(4);

    // random phase
    cur_tag = "";
    for (int i = 0; i < 15000; i++) begin
      logic [2:0] a;
      logic [7:0] d;
      if ($urandom_range(0, 40) == 0) gate = 2'($urandom());
      if ($urandom_range(0, 10) == 0) pin = 2'($urandom());
      a = 3'($urandom_range(0, 7));
      d = 8'($urandom());
      if (a == 3'd1 && $urandom_range(0, 1) == 1) d[1:0] = 2'b11;
      cycle($urandom_range(0, 9) == 0, a, d);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule